// File: doc/BRIEF.md
# I2C Master Start Condition Generator

This block produces the Start condition that opens every transfer by an I2C bus master. A one-cycle request from software raises a self-clearing enable bit. The block first confirms that both bus lines read high. It then times two baud periods with one down-counter that it reloads for each period. At the end of the first period it pulls SDA low while SCL is still high, which is the Start. At the end of the second period the Start is complete. The enable bit then drops, SDA stays pulled low and a ready output tells the next transfer stage that it may take over the bus.

While the first period runs, the block watches the lines for another master. If a line is already low when the request arrives, if SCL falls during the first period, or if SDA is low when the first period ends, the block raises a sticky collision flag, abandons the Start and returns to idle. The start-seen flag, the completion flag and the collision flag all stay set until a write-one-to-clear pulse clears them.

Top module: `i2c_start_gen`

## Requirements
- R1: After a synchronous reset, `idle` is 1 and `sda_pull_low`, `start_en`, `start_seen`, `done_irq`, `coll_irq` and `ready` are all 0.
- R2: A `start_req` accepted in idle with `sda_in` and `scl_in` both 1 sets `start_en` and clears `idle` at the edge that samples it. This is edge 0. The first baud period lasts `reload`+1 clocks, so `sda_pull_low` rises at edge `reload`+1.
- R3: `start_seen` becomes 1 at the same edge at which `sda_pull_low` rises.
- R4: The second baud period also lasts `reload`+1 clocks. At edge 2·(`reload`+1), `done_irq` and `ready` rise, `start_en` clears, and `sda_pull_low` stays 1.
- R5: A `reload` of 0 gives baud periods of one clock each, so the pull-down starts at edge 1 and completion comes at edge 2.
- R6: If `sda_in` or `scl_in` is 0 when a request is sampled in idle, `coll_irq` rises at edge 0. The block stays idle, and `start_en` and `sda_pull_low` stay 0.
- R7: During the first period, `scl_in` at 0 on any edge, or `sda_in` at 0 on the edge that ends the period, sets `coll_irq` at that edge. The same edge clears `start_en`, sets `idle` and leaves SDA released.
- R8: A `start_req` that arrives while a Start is in progress or complete has no effect. The timing of the current Start does not change, and after completion `start_en` stays 0.
- R9: `clr_flags` clears flags with a one-cycle pulse: bit 0 clears `start_seen`, bit 1 clears `done_irq` and bit 2 clears `coll_irq`. The flag reads 0 after the next edge. If a set event and a clear pulse fall on the same edge, the set wins.
- R10: A `release_bus` pulse while `ready` is 1 returns the block to idle at the next edge: `sda_pull_low` and `ready` go to 0 and `idle` goes to 1. A new request can then be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request that sets the enable bit |
| release_bus | input | 1 | Next stage has taken the bus; return to idle |
| reload | input | BRG_W (8) | Baud counter reload value; one period is reload+1 clocks |
| sda_in | input | 1 | Sampled SDA line |
| scl_in | input | 1 | Sampled SCL line |
| clr_flags | input | 3 | Write-one-to-clear pulses: bit0 start_seen, bit1 done_irq, bit2 coll_irq |
| sda_pull_low | output | 1 | Open-drain drive-low enable for SDA |
| start_en | output | 1 | Self-clearing enable bit; high while a Start is in progress |
| start_seen | output | 1 | Sticky flag: Start driven onto the bus |
| done_irq | output | 1 | Sticky interrupt flag: Start complete |
| coll_irq | output | 1 | Sticky interrupt flag: bus collision during the Start |
| idle | output | 1 | Block is idle and will accept a request |
| ready | output | 1 | Start complete; SDA held low for the next stage |

## Verification
All results are registered. Each one appears just after a known edge, counted from edge 0, the edge that samples the request. `start_en` and the collision flag for a line that is already low appear at edge 0. The pull-down and `start_seen` appear at edge `reload`+1. Completion appears at edge 2·(`reload`+1). A collision caused by SCL dropping after edge d appears at edge d+1. The bench counts edges from edge 0, samples on the falling clock edge after each one, and compares every output against a value it derives from these edge numbers and the vector's reload value.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT1 = 2'd1,
    ST_HOLD2 = 2'd2,
    ST_DONE  = 2'd3
  } start_state_t;

  localparam int FLAG_SEEN = 0;
  localparam int FLAG_DONE = 1;
  localparam int FLAG_COLL = 2;
  localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/i2c_start_brg.sv
module i2c_start_brg #(
  parameter int BRG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [BRG_W-1:0] reload,
  output logic             at_zero
);
  logic [BRG_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= reload;
    else if (run && (cnt != '0))
      cnt <= cnt - 1'b1;
  end

  assign at_zero = (cnt == '0);
endmodule

// File: rtl/i2c_start_flags.sv
module i2c_start_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        q[i] <= 1'b0;
      else if (set_ev[i])
        q[i] <= 1'b1;
      else if (clr[i])
        q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_start_ctrl.sv
module i2c_start_ctrl
  import i2c_start_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic release_bus,
  input  logic sda_in,
  input  logic scl_in,
  input  logic at_zero,
  output logic brg_load,
  output logic brg_run,
  output logic ev_start,
  output logic ev_done,
  output logic ev_coll,
  output logic start_en,
  output logic sda_pull_low,
  output logic ready,
  output logic idle
);
  start_state_t state, nxt;

  always_comb begin
    nxt      = state;
    brg_load = 1'b0;
    ev_start = 1'b0;
    ev_done  = 1'b0;
    ev_coll  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start_req) begin
          if (sda_in && scl_in) begin
            brg_load = 1'b1;
            nxt      = ST_WAIT1;
          end else begin
            ev_coll = 1'b1;
          end
        end
      end
      ST_WAIT1: begin
        if (!scl_in || (at_zero && !sda_in)) begin
          ev_coll = 1'b1;
          nxt     = ST_IDLE;
        end else if (at_zero) begin
          ev_start = 1'b1;
          brg_load = 1'b1;
          nxt      = ST_HOLD2;
        end
      end
      ST_HOLD2: begin
        if (at_zero) begin
          ev_done = 1'b1;
          nxt     = ST_DONE;
        end
      end
      ST_DONE: begin
        if (release_bus) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign brg_run = ((state == ST_WAIT1) || (state == ST_HOLD2)) && !brg_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      start_en     <= 1'b0;
      sda_pull_low <= 1'b0;
      ready        <= 1'b0;
      idle         <= 1'b1;
    end else begin
      state        <= nxt;
      start_en     <= (nxt == ST_WAIT1) || (nxt == ST_HOLD2);
      sda_pull_low <= (nxt == ST_HOLD2) || (nxt == ST_DONE);
      ready        <= (nxt == ST_DONE);
      idle         <= (nxt == ST_IDLE);
    end
  end
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2c_start_pkg::*;
#(
  parameter int BRG_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_req,
  input  logic                 release_bus,
  input  logic [BRG_W-1:0]     reload,
  input  logic                 sda_in,
  input  logic                 scl_in,
  input  logic [NUM_FLAGS-1:0] clr_flags,
  output logic                 sda_pull_low,
  output logic                 start_en,
  output logic                 start_seen,
  output logic                 done_irq,
  output logic                 coll_irq,
  output logic                 idle,
  output logic                 ready
);
  logic at_zero, brg_load, brg_run;
  logic ev_start, ev_done, ev_coll;
  logic [NUM_FLAGS-1:0] set_ev, flag_q;

  i2c_start_brg #(.BRG_W(BRG_W)) u_brg (
    .clk     (clk),
    .rst     (rst),
    .load    (brg_load),
    .run     (brg_run),
    .reload  (reload),
    .at_zero (at_zero)
  );

  i2c_start_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start_req    (start_req),
    .release_bus  (release_bus),
    .sda_in       (sda_in),
    .scl_in       (scl_in),
    .at_zero      (at_zero),
    .brg_load     (brg_load),
    .brg_run      (brg_run),
    .ev_start     (ev_start),
    .ev_done      (ev_done),
    .ev_coll      (ev_coll),
    .start_en     (start_en),
    .sda_pull_low (sda_pull_low),
    .ready        (ready),
    .idle         (idle)
  );

  always_comb begin
    set_ev            = '0;
    set_ev[FLAG_SEEN] = ev_start;
    set_ev[FLAG_DONE] = ev_done;
    set_ev[FLAG_COLL] = ev_coll;
  end

  i2c_start_flags #(.N(NUM_FLAGS)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_ev (set_ev),
    .clr    (clr_flags),
    .q      (flag_q)
  );

  assign start_seen = flag_q[FLAG_SEEN];
  assign done_irq   = flag_q[FLAG_DONE];
  assign coll_irq   = flag_q[FLAG_COLL];
endmodule

// File: rtl/i2c_start_chk.sv
module i2c_start_chk (
  input logic clk,
  input logic rst,
  input logic sda_pull_low,
  input logic start_en,
  input logic start_seen,
  input logic done_irq,
  input logic coll_irq,
  input logic idle,
  input logic ready
);
  // R2: the enable bit can only rise out of idle
  a_r2_en_from_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(start_en) |-> $past(idle));

  // R3: pulling SDA low is always accompanied by the start-seen flag
  a_r3_seen_with_pull: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_low) |-> start_seen);

  // R4: completion clears the enable bit and raises ready
  a_r4_done_clears_en: assert property (@(posedge clk) disable iff (rst)
    $rose(done_irq) |-> (!start_en && ready && sda_pull_low));

  // R7: a collision leaves the block idle with SDA released
  a_r7_coll_aborts: assert property (@(posedge clk) disable iff (rst)
    $rose(coll_irq) |-> (idle && !sda_pull_low && !start_en));

  // R10: idle never drives SDA
  a_r10_idle_released: assert property (@(posedge clk) disable iff (rst)
    idle |-> (!sda_pull_low && !ready));
endmodule

bind i2c_start_gen i2c_start_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .sda_pull_low (sda_pull_low),
  .start_en     (start_en),
  .start_seen   (start_seen),
  .done_irq     (done_irq),
  .coll_irq     (coll_irq),
  .idle         (idle),
  .ready        (ready)
);

// File: tb/i2c_start_gen_test.sv
module i2c_start_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  // vector: reload[17:10], sda0[9], scl0[8], drop edge[7:0] (8'hFF = none)
  localparam logic [17:0] VEC [NV] = '{
    {8'd3, 1'b1, 1'b1, 8'hFF},
    {8'd0, 1'b1, 1'b1, 8'hFF},
    {8'd5, 1'b1, 1'b1, 8'hFF},
    {8'd1, 1'b0, 1'b1, 8'hFF},
    {8'd2, 1'b1, 1'b0, 8'hFF},
    {8'd0, 1'b0, 1'b0, 8'hFF},
    {8'd4, 1'b1, 1'b1, 8'd2},
    {8'd4, 1'b1, 1'b1, 8'd0},
    {8'd3, 1'b1, 1'b1, 8'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0;
  logic release_bus = 1'b0;
  logic [7:0] reload = '0;
  logic sda_in = 1'b1;
  logic scl_in = 1'b1;
  logic [2:0] clr_flags = '0;
  logic sda_pull_low, start_en, start_seen, done_irq, coll_irq, idle, ready;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_start_gen uut (
    .clk(clk), .rst(rst), .start_req(start_req), .release_bus(release_bus),
    .reload(reload), .sda_in(sda_in), .scl_in(scl_in), .clr_flags(clr_flags),
    .sda_pull_low(sda_pull_low), .start_en(start_en), .start_seen(start_seen),
    .done_irq(done_irq), .coll_irq(coll_irq), .idle(idle), .ready(ready)
  );

  // packed order: pull, en, seen, done, coll, idle, ready
  function automatic logic [6:0] outs();
    return {sda_pull_low, start_en, start_seen, done_irq, coll_irq, idle, ready};
  endfunction

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b (pull,en,seen,done,coll,idle,ready)", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    start_req = 1'b0; release_bus = 1'b0; clr_flags = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // drive request at a negedge; return at the negedge following edge 0
  task automatic request();
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    check("R1", outs(), 7'b0000010);

    for (int v = 0; v < NV; v++) begin
      int r, d, last;
      logic s0, c0;
      bit initcoll, dropcoll;
      r  = int'(VEC[v][17:10]);
      s0 = VEC[v][9];
      c0 = VEC[v][8];
      d  = int'(VEC[v][7:0]);
      do_reset();
      reload = r[7:0];
      sda_in = s0;
      scl_in = c0;
      initcoll = !(s0 && c0);
      dropcoll = !initcoll && (d != 255) && (d <= r);
      last = 2 * r + 3;
      request();
      for (int k = 0; k <= last; k++) begin
        logic [6:0] exp;
        string tag;
        if (initcoll) begin
          exp = 7'b0000110; tag = "R6";
        end else if (dropcoll) begin
          exp = (k >= d + 1) ? 7'b0000110 : 7'b0100000; tag = "R7";
        end else begin
          exp[6] = (k >= r + 1);
          exp[5] = (k < 2 * r + 2);
          exp[4] = (k >= r + 1);
          exp[3] = (k >= 2 * r + 2);
          exp[2] = 1'b0;
          exp[1] = 1'b0;
          exp[0] = (k >= 2 * r + 2);
          tag = (r == 0) ? "R5" : ((k <= r + 1) ? "R2/R3" : "R4");
        end
        check(tag, outs(), exp);
        if (!initcoll && d != 255 && k == d) scl_in = 1'b0;
        @(negedge clk);
      end
    end

    // R8: repeated requests during and after the Start are ignored
    do_reset();
    reload = 8'd2; sda_in = 1'b1; scl_in = 1'b1;
    request();                       // now after edge 0
    start_req = 1'b1; @(negedge clk); start_req = 1'b0;   // after edge 1
    repeat (3) @(negedge clk);       // after edge 4
    check("R8 busy", outs(), 7'b1110000);
    @(negedge clk);                  // after edge 5
    check("R8 busy", outs(), 7'b1110000);
    @(negedge clk);                  // after edge 6
    check("R8 timing", outs(), 7'b1011001);
    start_req = 1'b1; @(negedge clk); start_req = 1'b0;
    @(negedge clk);
    check("R8 done", outs(), 7'b1011001);

    // R9: write-one-to-clear of start_seen and done_irq
    clr_flags = 3'b001; @(negedge clk); clr_flags = '0;
    check("R9 seen", outs(), 7'b1001001);
    clr_flags = 3'b010; @(negedge clk); clr_flags = '0;
    check("R9 done", outs(), 7'b1000001);

    // R10: release returns to idle; a new Start is accepted
    release_bus = 1'b1; @(negedge clk); release_bus = 1'b0;
    check("R10 release", outs(), 7'b0000010);
    request();
    check("R10 restart", outs(), 7'b0100000);

    // R9: collision flag clear; set wins over a simultaneous clear
    do_reset();
    sda_in = 1'b0;
    start_req = 1'b1; clr_flags = 3'b100; @(negedge clk);
    start_req = 1'b0; clr_flags = '0;
    check("R9 set wins", outs(), 7'b0000110);
    clr_flags = 3'b100; @(negedge clk); clr_flags = '0;
    check("R9 coll clear", outs(), 7'b0000010);
    sda_in = 1'b1;

    // R7: SDA low when the first period expires
    do_reset();
    reload = 8'd1; sda_in = 1'b1; scl_in = 1'b1;
    request();                       // after edge 0
    sda_in = 1'b0;
    @(negedge clk);                  // after edge 1, still counting
    check("R7 sda wait", outs(), 7'b0100000);
    @(negedge clk);                  // after edge 2, period ends with SDA low
    check("R7 sda low", outs(), 7'b0000110);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule